// File: doc/BRIEF.md
# Paired-Character Software Flow Controller

This block gives one serial channel automatic software flow control in which every flow command is a two-byte sequence. Four programmable bytes define the sequences: a stop pair (stop lead, stop tail) and a resume pair (resume lead, resume tail). On the receive side the block sits between the byte deserializer and the receive queue. It takes each received byte and consumes any stop or resume pair whose two bytes arrive back to back. A matched stop pair raises a pause flag for the local transmitter, and a matched resume pair clears it. Every other byte passes on to the queue in its original order. A lead byte that stands alone, or that is followed by any byte other than its tail, is therefore ordinary data.

On the transmit side the block watches a level signal from the receive queue, which is high while the queue holds at least its trigger level. When that level rises, the block asks the serializer to send the stop pair. When it falls after a stop pair was sent, the block asks for the resume pair. Each byte of a pair is offered until the serializer acknowledges it. A new pair is only offered while no character is in flight. While a request is pending the serializer sends it ahead of queued data, and it sends requested bytes even while the pause flag is set.

Top module: `xonxoff_pair_ctl`

## Requirements
- R1: After reset tx_pause is 0, ins_valid is 0 and fwd_cnt is 0.
- R2: A stop lead byte followed on the very next rx_valid by the stop tail byte sets tx_pause in the cycle after the tail is presented. A resume lead followed by a resume tail clears it the same way. Neither byte of a matched pair is ever forwarded.
- R3: A lead byte not followed by its own tail is forwarded, followed by the byte after it if that byte is not itself a lead. A lead byte is held back until the next received byte decides it.
- R4: If the byte after a lead byte is itself a lead byte of either pair, the earlier lead is forwarded and matching restarts from the new byte.
- R5: Forwarded bytes appear in the cycle after the rx_valid that decides them. fwd_cnt (0, 1 or 2) gives the number of valid bytes in the cycle, and fwd_first is older than fwd_second.
- R6: When rxq_high rises, ins_valid goes high with ins_byte equal to the stop lead. After ins_ack the stop tail is offered. After a second ins_ack ins_valid drops. The offered byte is held unchanged until it is acknowledged.
- R7: When rxq_high falls after a stop pair was sent, the resume pair is offered in the same lead-then-tail order. No pair is offered again while rxq_high keeps its value.
- R8: A pair starts only in a cycle in which tx_busy was low. While tx_busy is high a pending request waits.
- R9: tx_pause changes only in the cycle after an rx_valid. Insertion traffic never alters it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| xoff_a | input | W | Stop pair lead byte |
| xoff_b | input | W | Stop pair tail byte |
| xon_a | input | W | Resume pair lead byte |
| xon_b | input | W | Resume pair tail byte |
| rx_valid | input | 1 | A received byte is presented this cycle |
| rx_byte | input | W | Received byte |
| rxq_high | input | 1 | Receive queue at or above its trigger level |
| tx_busy | input | 1 | Serializer is sending a character |
| ins_ack | input | 1 | Serializer took the offered flow byte |
| tx_pause | output | 1 | Remote end asked the local transmitter to stop |
| fwd_cnt | output | 2 | Number of bytes forwarded to the receive queue this cycle |
| fwd_first | output | W | Older forwarded byte |
| fwd_second | output | W | Newer forwarded byte |
| ins_valid | output | 1 | A flow byte is offered for transmission |
| ins_byte | output | W | Offered flow byte |

## Verification
A matcher left in the wrong state shows up at the forwarding port within one received byte. A lead byte that was held when it should not be appears as a missing or reordered byte in fwd_first/fwd_second. A tail byte matched against the wrong lead appears as a wrong tx_pause level one cycle later. The sweep feeds every three-byte sequence over the four flow bytes and one plain byte, followed by a plain closing byte, so each of these errors is seen within the sequence that causes it. A wrong record of the last pair sent shows up as a repeated or missing pair on ins_valid in the first idle cycle after rxq_high moves.

// File: rtl/xonxoff_pair_ctl.sv
module xonxoff_pair_ctl #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] xoff_a,
  input  logic [W-1:0] xoff_b,
  input  logic [W-1:0] xon_a,
  input  logic [W-1:0] xon_b,
  input  logic         rx_valid,
  input  logic [W-1:0] rx_byte,
  input  logic         rxq_high,
  input  logic         tx_busy,
  input  logic         ins_ack,
  output logic         tx_pause,
  output logic [1:0]   fwd_cnt,
  output logic [W-1:0] fwd_first,
  output logic [W-1:0] fwd_second,
  output logic         ins_valid,
  output logic [W-1:0] ins_byte
);

  typedef enum logic [1:0] {M_IDLE, M_ON, M_OFF} mst_t;
  typedef enum logic [1:0] {I_IDLE, I_FIRST, I_SECOND} ist_t;

  mst_t         m_st;
  ist_t         i_st;
  logic [W-1:0] hold;
  logic         sent_off, pair_off;

  wire  is_lead  = (rx_byte == xon_a) || (rx_byte == xoff_a);
  wire  mst_t nxt = (rx_byte == xon_a) ? M_ON : M_OFF;
  wire  tail_hit = (m_st == M_ON  && rx_byte == xon_b) ||
                   (m_st == M_OFF && rx_byte == xoff_b);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      m_st       <= M_IDLE;
      tx_pause   <= 1'b0;
      fwd_cnt    <= 2'd0;
      fwd_first  <= '0;
      fwd_second <= '0;
      hold       <= '0;
    end else begin
      fwd_cnt <= 2'd0;
      if (rx_valid) begin
        if (m_st == M_IDLE) begin
          if (is_lead) begin
            m_st <= nxt;
            hold <= rx_byte;
          end else begin
            fwd_cnt   <= 2'd1;
            fwd_first <= rx_byte;
          end
        end else if (tail_hit) begin
          tx_pause <= (m_st == M_OFF);
          m_st     <= M_IDLE;
        end else begin
          fwd_first <= hold;
          if (is_lead) begin
            fwd_cnt <= 2'd1;
            m_st    <= nxt;
            hold    <= rx_byte;
          end else begin
            fwd_cnt    <= 2'd2;
            fwd_second <= rx_byte;
            m_st       <= M_IDLE;
          end
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      i_st     <= I_IDLE;
      sent_off <= 1'b0;
      pair_off <= 1'b0;
    end else begin
      case (i_st)
        I_IDLE: if (!tx_busy && (rxq_high != sent_off)) begin
          i_st     <= I_FIRST;
          pair_off <= rxq_high;
          sent_off <= rxq_high;
        end
        I_FIRST:  if (ins_ack) i_st <= I_SECOND;
        I_SECOND: if (ins_ack) i_st <= I_IDLE;
        default:  i_st <= I_IDLE;
      endcase
    end
  end

  assign ins_valid = (i_st != I_IDLE);
  assign ins_byte  = pair_off ? ((i_st == I_FIRST) ? xoff_a : xoff_b)
                              : ((i_st == I_FIRST) ? xon_a  : xon_b);

  a_r6_offer_held: assert property (@(posedge clk) disable iff (!rst_n)
    (ins_valid && !ins_ack) |=> (ins_valid && $stable(ins_byte)));

  a_r8_start_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ins_valid) |-> !$past(tx_busy));

  a_r9_pause_only_after_rx: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(rx_valid) |-> $stable(tx_pause));

  a_r5_fwd_only_after_rx: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(rx_valid) |-> (fwd_cnt == 2'd0));

endmodule

// File: tb/xonxoff_pair_ctl_tb_top.sv
module xonxoff_pair_ctl_tb_top;
  localparam int W = 8;
  localparam logic [W-1:0] OFF_A = 8'h13, OFF_B = 8'h93, ON_A = 8'h11, ON_B = 8'h91, PLAIN = 8'h41;

  logic clk = 0, rst_n = 0;
  logic rx_valid = 0, rxq_high = 0, tx_busy = 0, ins_ack = 0;
  logic [W-1:0] rx_byte = '0;
  logic tx_pause, ins_valid;
  logic [1:0] fwd_cnt;
  logic [W-1:0] fwd_first, fwd_second, ins_byte;

  int checks = 0, fails = 0;
  logic [W-1:0] got [0:7];
  int ngot = 0;

  always #5 clk = ~clk;

  xonxoff_pair_ctl #(.W(W)) dut_i (
    .clk(clk), .rst_n(rst_n), .xoff_a(OFF_A), .xoff_b(OFF_B), .xon_a(ON_A), .xon_b(ON_B),
    .rx_valid(rx_valid), .rx_byte(rx_byte), .rxq_high(rxq_high), .tx_busy(tx_busy),
    .ins_ack(ins_ack), .tx_pause(tx_pause), .fwd_cnt(fwd_cnt), .fwd_first(fwd_first),
    .fwd_second(fwd_second), .ins_valid(ins_valid), .ins_byte(ins_byte));

  always @(negedge clk) begin
    if (rst_n && fwd_cnt >= 2'd1 && ngot < 8) begin got[ngot] = fwd_first; ngot++; end
    if (rst_n && fwd_cnt == 2'd2 && ngot < 8) begin got[ngot] = fwd_second; ngot++; end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk) rst_n = 0;
    @(negedge clk);
    @(negedge clk) rst_n = 1;
    ngot = 0;
  endtask

  task automatic send(input logic [W-1:0] b);
    @(negedge clk) begin rx_valid = 1; rx_byte = b; end
    @(negedge clk) rx_valid = 0;
  endtask

  task automatic ack();
    @(negedge clk) ins_ack = 1;
    @(negedge clk) ins_ack = 0;
  endtask

  initial begin
    #2000000;
    fails++; checks++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    logic [W-1:0] sym [0:4];
    logic [W-1:0] seq [0:3];
    logic [W-1:0] expb [0:7];
    int nexp;
    bit pause_exp;
    sym[0] = ON_A; sym[1] = ON_B; sym[2] = OFF_A; sym[3] = OFF_B; sym[4] = PLAIN;

    do_reset();
    check(tx_pause == 0 && ins_valid == 0 && fwd_cnt == 0, "R1 reset", {tx_pause, ins_valid, fwd_cnt}, 0);

    // R2 R3 R4 R5: every 3-byte sequence plus a closing plain byte
    for (int a = 0; a < 5; a++)
      for (int b = 0; b < 5; b++)
        for (int c = 0; c < 5; c++) begin
          seq[0] = sym[a]; seq[1] = sym[b]; seq[2] = sym[c]; seq[3] = PLAIN;
          nexp = 0; pause_exp = 0;
          for (int i = 0; i < 4; ) begin
            if (i < 3 && seq[i] == OFF_A && seq[i+1] == OFF_B) begin pause_exp = 1; i += 2; end
            else if (i < 3 && seq[i] == ON_A && seq[i+1] == ON_B) begin pause_exp = 0; i += 2; end
            else begin expb[nexp] = seq[i]; nexp++; i++; end
          end
          do_reset();
          for (int i = 0; i < 4; i++) send(seq[i]);
          @(negedge clk);
          check(ngot == nexp, "R3 forwarded count", ngot, nexp);
          for (int i = 0; i < nexp && i < ngot; i++)
            check(got[i] == expb[i], "R4 forwarded order", got[i], expb[i]);
          check(tx_pause == pause_exp, "R2 pause level", tx_pause, pause_exp);
        end

    // R5: two bytes in one cycle, older first
    do_reset();
    @(negedge clk) begin rx_valid = 1; rx_byte = ON_A; end
    @(negedge clk) begin rx_byte = PLAIN; end
    check(fwd_cnt == 0, "R5 lead held", fwd_cnt, 0);
    @(negedge clk) rx_valid = 0;
    check(fwd_cnt == 2 && fwd_first == ON_A && fwd_second == PLAIN, "R5 two lanes",
          {fwd_cnt, fwd_first, fwd_second}, {2'd2, ON_A, PLAIN});

    // R2: pause timing after tail
    do_reset();
    send(OFF_A);
    @(negedge clk) begin rx_valid = 1; rx_byte = OFF_B; end
    check(tx_pause == 0, "R2 not before tail", tx_pause, 0);
    @(negedge clk) rx_valid = 0;
    check(tx_pause == 1, "R2 set after tail", tx_pause, 1);

    // R6 R7 R8 R9: insertion
    repeat (3) @(negedge clk);
    check(ins_valid == 0, "R7 no pair without change", ins_valid, 0);
    tx_busy = 1; rxq_high = 1;
    repeat (3) @(negedge clk);
    check(ins_valid == 0, "R8 wait while busy", ins_valid, 0);
    tx_busy = 0;
    @(negedge clk);
    check(ins_valid == 1 && ins_byte == OFF_A, "R6 stop lead", ins_byte, OFF_A);
    repeat (3) @(negedge clk);
    check(ins_valid == 1 && ins_byte == OFF_A, "R6 held until ack", ins_byte, OFF_A);
    ack();
    check(ins_valid == 1 && ins_byte == OFF_B, "R6 stop tail", ins_byte, OFF_B);
    ack();
    check(ins_valid == 0, "R6 pair done", ins_valid, 0);
    repeat (4) @(negedge clk);
    check(ins_valid == 0, "R7 no repeat", ins_valid, 0);
    check(tx_pause == 1, "R9 pause untouched by insertion", tx_pause, 1);
    rxq_high = 0;
    @(negedge clk);
    check(ins_valid == 1 && ins_byte == ON_A, "R7 resume lead", ins_byte, ON_A);
    ack();
    check(ins_valid == 1 && ins_byte == ON_B, "R7 resume tail", ins_byte, ON_B);
    ack();
    check(ins_valid == 0, "R7 resume done", ins_valid, 0);
    send(ON_A); send(ON_B);
    check(tx_pause == 0, "R2 cleared by resume pair", tx_pause, 0);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule